// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides, in the same cycle, whether an instruction may touch a control/status register. It sits next to the register file of a processor core and looks at the 12-bit register address together with the hart's current privilege level, a debug-mode flag, the kind of access operation, whether the operation's source operand is zero, the configured register width and an "address implemented" flag from the register file. It produces `allow` and its complement `illegal_insn`, which the core turns into an illegal-instruction trap.

Rights come straight from the address bits. The two top bits mark a register as read-only when both are set. The next two bits give the lowest privilege level that may reach it. A sixteen-entry window is reserved for debug mode. Two 32-entry windows hold the upper halves of 64-bit counters, and these exist only when the register width is 32 bits. Debug mode carries at least machine rights for every check. A set-bits or clear-bits operation with a zero source changes nothing, so it counts as a read.

All pins are plain control and status signals with no handshake. The outputs depend only on the present inputs, so there is no back-pressure and no latency.

Top module: `csr_access_checker`

## Requirements
- R1: A read (`op_kind` 2'b00) of an implemented register whose address bits [11:8] are 4'b0000 is allowed at every privilege level.
- R2: Address bits [9:8] give the minimum level, encoded 0 user, 1 supervisor, 2 hypervisor, 3 machine (same encoding on `priv_lvl`). An access from a lower level is illegal. An equal or higher level passes this check.
- R3: When address bits [11:10] are 2'b11, any write intent makes the access illegal, and a read passes this check.
- R4: `op_kind` is 2'b00 read, 2'b01 swap, 2'b10 set bits, 2'b11 clear bits. A swap always counts as a write. Set and clear count as writes only when `src_zero` is 0.
- R5: Addresses 0x7B0 to 0x7BF are illegal whenever `dbg_mode` is 0, including at machine level.
- R6: Addresses 0x7A0 to 0x7AF behave as ordinary machine read/write registers, with no debug-mode restriction.
- R7: With `dbg_mode` 1, every privilege comparison is made as machine level, whatever `priv_lvl` holds.
- R8: With `addr_present` 0, the access is illegal regardless of all other inputs.
- R9: Addresses 0xB80 to 0xB9F and 0xC80 to 0xC9F are illegal when `xlen_is32` is 0, and are subject only to the other rules when it is 1.
- R10: `illegal_insn` is always the inverse of `allow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | Register address of the access |
| priv_lvl | input | 2 | Current privilege level of the hart |
| dbg_mode | input | 1 | Hart is in debug mode |
| op_kind | input | 2 | Access operation: read, swap, set bits, clear bits |
| src_zero | input | 1 | Source operand of the operation is zero |
| xlen_is32 | input | 1 | Register width is 32 bits |
| addr_present | input | 1 | Register file implements this address |
| allow | output | 1 | Access may proceed |
| illegal_insn | output | 1 | Access must raise an illegal-instruction trap |

## Verification
The assertions assume that all inputs are settled, known values whenever they are evaluated. They also assume that `priv_lvl` carries one of the four defined encodings, so the ordering of levels is meaningful. The bench changes inputs only just after a rising edge and samples at the falling edge, so every comparison sees a stable input set. It sweeps the full 4096-entry address space and drives pseudo-random level, mode and operation values, which are legal by construction. The directed cases sit on the edges of each special window.

// File: rtl/csr_acc_pkg.sv
package csr_acc_pkg;
  localparam int unsigned CSR_AW  = 12;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned TAG_W   = 8;   // address bits [11:4]
  localparam int unsigned HHPFX_W = 7;   // address bits [11:5]

  typedef enum logic [LVL_W-1:0] {
    LVL_U = 2'd0,
    LVL_S = 2'd1,
    LVL_H = 2'd2,
    LVL_M = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_SWAP = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } csr_op_e;
endpackage

// File: rtl/csr_wr_intent.sv
module csr_wr_intent
  import csr_acc_pkg::*;
(
  input  logic [1:0] op_kind,
  input  logic       src_zero,
  output logic       wr_intent
);
  csr_op_e op;
  assign op = csr_op_e'(op_kind);

  always_comb begin
    unique case (op)
      OP_SWAP:        wr_intent = 1'b1;
      OP_SET, OP_CLR: wr_intent = ~src_zero;
      default:        wr_intent = 1'b0;
    endcase
  end

  // R4: a zero-source set/clear and a plain read never carry write intent
  always_comb begin
    a_r4_zero_src_is_read: assert (!((op != OP_SWAP) && (op == OP_READ || src_zero) && wr_intent))
      else $error("R4 write intent on non-writing op");
  end
endmodule

// File: rtl/csr_priv_gate.sv
module csr_priv_gate
  import csr_acc_pkg::*;
#(
  parameter logic [TAG_W-1:0] DBG_TAG = 8'h7B
) (
  input  logic [TAG_W-1:0] addr_tag,
  input  logic [LVL_W-1:0] min_lvl,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             dbg_mode,
  output logic             lvl_ok,
  output logic             dbg_ok
);
  logic [LVL_W-1:0] eff_lvl;
  logic             in_dbg_win;

  assign eff_lvl    = dbg_mode ? LVL_M : cur_lvl;
  assign lvl_ok     = (eff_lvl >= min_lvl);
  assign in_dbg_win = (addr_tag == DBG_TAG);
  assign dbg_ok     = dbg_mode | ~in_dbg_win;

  // R7: debug mode clears every level comparison
  always_comb begin
    a_r7_dbg_is_machine: assert (!dbg_mode || lvl_ok)
      else $error("R7 debug mode failed level check");
  end
endmodule

// File: rtl/csr_range_gate.sv
module csr_range_gate
  import csr_acc_pkg::*;
#(
  parameter int unsigned                    HH_N   = 2,
  parameter logic [HH_N-1:0][HHPFX_W-1:0]   HH_PFX = {7'h64, 7'h5C}
) (
  input  logic [HHPFX_W-1:0] addr_hi,
  input  logic               wr_intent,
  input  logic               xlen_is32,
  output logic               ro_ok,
  output logic               hh_ok
);
  localparam int unsigned RO_SHIFT = HHPFX_W - 2;

  logic [HH_N-1:0] hh_hit;
  logic            is_ro;

  for (genvar g = 0; g < HH_N; g++) begin : g_hh
    assign hh_hit[g] = (addr_hi == HH_PFX[g]);
  end

  assign is_ro = &addr_hi[HHPFX_W-1:RO_SHIFT];
  assign ro_ok = ~(is_ro & wr_intent);
  assign hh_ok = xlen_is32 | ~(|hh_hit);

  // R9: with 32-bit width the high-half windows never block
  always_comb begin
    a_r9_hh_open_on_32: assert (!xlen_is32 || hh_ok)
      else $error("R9 high-half blocked on 32-bit width");
  end
endmodule

// File: rtl/csr_access_checker.sv
module csr_access_checker
  import csr_acc_pkg::*;
(
  input  logic [11:0] csr_addr,
  input  logic [1:0]  priv_lvl,
  input  logic        dbg_mode,
  input  logic [1:0]  op_kind,
  input  logic        src_zero,
  input  logic        xlen_is32,
  input  logic        addr_present,
  output logic        allow,
  output logic        illegal_insn
);
  localparam int unsigned TAG_LSB = CSR_AW - TAG_W;
  localparam int unsigned HH_LSB  = CSR_AW - HHPFX_W;
  localparam int unsigned LVL_LSB = CSR_AW - 4;

  logic wr_intent, lvl_ok, dbg_ok, ro_ok, hh_ok;

  csr_wr_intent u_intent (
    .op_kind   (op_kind),
    .src_zero  (src_zero),
    .wr_intent (wr_intent)
  );

  csr_priv_gate #(.DBG_TAG(8'h7B)) u_priv (
    .addr_tag (csr_addr[CSR_AW-1:TAG_LSB]),
    .min_lvl  (csr_addr[LVL_LSB+LVL_W-1:LVL_LSB]),
    .cur_lvl  (priv_lvl),
    .dbg_mode (dbg_mode),
    .lvl_ok   (lvl_ok),
    .dbg_ok   (dbg_ok)
  );

  csr_range_gate #(.HH_N(2), .HH_PFX({7'h64, 7'h5C})) u_range (
    .addr_hi   (csr_addr[CSR_AW-1:HH_LSB]),
    .wr_intent (wr_intent),
    .xlen_is32 (xlen_is32),
    .ro_ok     (ro_ok),
    .hh_ok     (hh_ok)
  );

  assign allow        = addr_present & lvl_ok & dbg_ok & ro_ok & hh_ok;
  assign illegal_insn = ~allow;

  always_comb begin
    // R8: unimplemented address never passes
    a_r8_absent_blocks: assert (addr_present || illegal_insn)
      else $error("R8 absent address allowed");
    // R3: write to read-only space traps
    a_r3_ro_write_traps: assert (!((csr_addr[11:10] == 2'b11) && (op_kind == 2'b01)) || illegal_insn)
      else $error("R3 swap to read-only allowed");
    // R5: debug window closed outside debug mode
    a_r5_dbg_window: assert (!((csr_addr[11:4] == 8'h7B) && !dbg_mode) || illegal_insn)
      else $error("R5 debug window open");
    // R9: high-half windows closed on 64-bit width
    a_r9_hh_closed_on_64: assert (xlen_is32 || !((csr_addr[11:5] == 7'h64) || (csr_addr[11:5] == 7'h5C)) || illegal_insn)
      else $error("R9 high-half open on 64-bit");
    // R2: below-minimum level traps outside debug mode
    a_r2_level_floor: assert (dbg_mode || (priv_lvl >= csr_addr[9:8]) || illegal_insn)
      else $error("R2 low level allowed");
  end
endmodule

// File: tb/csr_access_checker_tb_top.sv
module csr_access_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  priv_lvl = '0;
  logic        dbg_mode = 1'b0;
  logic [1:0]  op_kind = '0;
  logic        src_zero = 1'b0;
  logic        xlen_is32 = 1'b0;
  logic        addr_present = 1'b0;
  logic        allow, illegal_insn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  csr_access_checker dut_i (
    .csr_addr(csr_addr), .priv_lvl(priv_lvl), .dbg_mode(dbg_mode),
    .op_kind(op_kind), .src_zero(src_zero), .xlen_is32(xlen_is32),
    .addr_present(addr_present), .allow(allow), .illegal_insn(illegal_insn)
  );

  function automatic bit ref_allow(logic [11:0] a, logic [1:0] lvl, logic dbg,
                                   logic [1:0] op, logic sz, logic x32, logic pres);
    bit writes;
    int eff;
    writes = (op == 2'd1) || ((op >= 2'd2) && !sz);
    eff    = dbg ? 3 : int'(lvl);
    if (!pres) return 1'b0;
    if (eff < int'(a[9:8])) return 1'b0;
    if (a[11:10] == 2'b11 && writes) return 1'b0;
    if (a >= 12'h7B0 && a <= 12'h7BF && !dbg) return 1'b0;
    if (((a >= 12'hB80 && a <= 12'hB9F) || (a >= 12'hC80 && a <= 12'hC9F)) && !x32) return 1'b0;
    return 1'b1;
  endfunction

  task automatic apply(input logic [11:0] a, input logic [1:0] lvl, input logic dbg,
                       input logic [1:0] op, input logic sz, input logic x32,
                       input logic pres, input string req);
    bit exp;
    @(posedge clk); #1;
    csr_addr = a; priv_lvl = lvl; dbg_mode = dbg; op_kind = op;
    src_zero = sz; xlen_is32 = x32; addr_present = pres;
    exp = ref_allow(a, lvl, dbg, op, sz, x32, pres);
    @(negedge clk);
    checks++;
    if (allow !== exp || illegal_insn !== ~exp) begin
      failures++;
      $display("FAIL %s addr=%h allow=%b illegal=%b expected allow=%b illegal=%b",
               req, a, allow, illegal_insn, exp, ~exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    lf = 32'hACE1_2345;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R8 reset state: all inputs zero -> illegal
    apply(12'h000, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R8_reset");
    // R1 user read space
    apply(12'h001, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R1_user_read");
    apply(12'h0FF, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, "R1_user_swap");
    // R2 level floor
    apply(12'h300, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R2_s_to_m");
    apply(12'h300, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R2_m_to_m");
    apply(12'h200, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R2_s_to_h");
    apply(12'h100, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R2_h_to_s");
    // R3 read-only space
    apply(12'hF11, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, "R3_ro_swap");
    apply(12'hF11, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R3_ro_read");
    // R4 set/clear intent
    apply(12'hC00, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, "R4_set_zero");
    apply(12'hC00, 2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, "R4_clr_nonzero");
    apply(12'hC00, 2'd0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, "R4_swap_zero");
    // R5 debug window
    apply(12'h7B0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R5_m_no_dbg");
    apply(12'h7BF, 2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, "R5_dbg_top");
    apply(12'h7C0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R5_above_win");
    // R6 trigger window ordinary
    apply(12'h7A0, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, "R6_m_swap");
    apply(12'h7AF, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R6_s_read");
    // R7 debug as machine
    apply(12'h344, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, "R7_dbg_user");
    // R9 high halves
    apply(12'hC80, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R9_c80_64");
    apply(12'hC9F, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, "R9_c9f_32");
    apply(12'hCA0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R9_above_64");
    apply(12'hB80, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, "R9_b80_64");
    apply(12'hB9F, 2'd3, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, "R9_b9f_32");
    apply(12'hB7F, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, "R9_below_64");
    // R8 absent even with machine debug
    apply(12'h300, 2'd3, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, "R8_absent");
    // R10 sweep: complement and all rules over the whole space
    for (int i = 0; i < 4096; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      apply(12'(i), lf[1:0], lf[2] & lf[7], lf[4:3], lf[5], lf[6], lf[8] | lf[9],
            "R10_sweep");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule